// File: doc/BRIEF.md
# Memory controller configuration register file

This block is the software-visible register file of an external-memory controller that serves eight chip selects. A 32-bit bus master reaches it through one write strobe and one read strobe over a 4 KB byte-addressed window. It stores the global control, interrupt, timeout, prefetch and error-correction control settings. It also stores seven configuration words for each chip select. Every register applies its own write mask and loads its own reset value. A few offsets return fixed identification or status constants. The prefetch status word is not stored; it is built on every read from live state.

The block does not run the external bus, move NAND data, compute parity or fetch ahead. It only holds the settings those engines use. All 56 chip-select words leave on one flat bus, where an address decoder and the timing engine pick them up. Hardware events set interrupt status bits, and a level interrupt reports any status bit that is enabled. Writing the self-reset bit returns every register to its reset state in a single cycle. A one-cycle strobe tells the parity accumulators to clear.

Writes take effect on the clock edge on which `wr_en` is high. Reads are combinational: while `rd_en` is high, `rdata` shows the addressed word, and it is 0 otherwise.

Top module: `memcfg_regfile`

## Requirements
- R1: Offset 0x000 reads 0x20, offset 0x014 reads 1 and offset 0x054 reads 1. Writes to these offsets, and to 0x1F0, change nothing.
- R2: The system register at 0x010 stores the write data masked by 0x19 and resets to 0. A write to it with bit 1 set first returns every other register to its reset value in that same cycle, including interrupt status and enable. It also raises `ecc_clr_o`.
- R3: The interrupt enable register at 0x01C stores data masked by 0xF03. Each `irq_evt` bit inside mask 0xF03 sets the matching status bit at 0x018. Writing 1 to a status bit clears it. When an event and a clear hit the same bit in the same cycle, the event wins.
- R4: `irq_o` is high in the cycle after a change exactly when some bit is set in both the status register and the enable register.
- R5: The timeout register at 0x040 uses mask 0x1FF1 and resets to 0. The global control register at 0x050 uses mask 0xF13 and resets to 0xA00.
- R6: Chip select n owns words k = 0..6 at byte address 0x060 + n*0x30 + k*4. Their masks, for k = 0..6, are FFEF3E13, 001F1F8F, 001F1F8F, 1F8F1F8F, 0F1F1F1F, 00000FCF and 00000F7F. Word k of chip select n appears on `cs_cfg_o[(n*7+k)*32 +: 32]`.
- R7: Chip-select reset values are as follows. Word 0 is 0 for chip select 0 and 0x1000 for the others. Words 1 to 5 are 0x101001, 0x020201, 0x10031003, 0x010F1111 and 0. Word 6 is 0xF40 for chip select 0 and 0xF00 for the others.
- R8: Prefetch setup 1 at 0x1E0 uses mask 0x7F8F7FBF and resets to 0x4000. Prefetch setup 2 at 0x1E4 uses mask 0x3FFF and resets to 0. The prefetch start register at 0x1EC stores data bit 0. When that bit is written as 1, the fill count loads 0x40 if bit 0 of setup 1 is set, and 0 if it is clear. Writing 0 leaves the count unchanged.
- R9: Prefetch status at 0x1F0 reads as follows: the fill count in bits [30:24], and bit 16 high only when the count is strictly greater than bits [14:8] of setup 1. All other bits read 0.
- R10: Any write to 0x1F4 sets that register to 0x8F. A write to 0x1F8 loads data bits [3:0] as the result pointer, which is readable at 0x1F8. A value of 0 or greater than 9 stores 0 instead and clears bit 0 of 0x1F4. Data bit 8 raises `ecc_clr_o` for the one cycle that follows the write.
- R11: The parity size register at 0x1FC uses mask 0x3FCFF1FF and resets to 0x3FCFF000.
- R12: All other offsets read 0 and ignore writes. This includes the unused words at offsets 0x1C to 0x2C of each chip-select block and any address that is not word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the addressed register |
| rd_en | input | 1 | Read strobe; gates `rdata` |
| addr | input | 12 | Byte address in the register window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| irq_evt | input | 16 | Hardware event pulses that set interrupt status |
| irq_o | output | 1 | Level interrupt |
| ecc_clr_o | output | 1 | One-cycle clear strobe for the parity accumulators |
| cs_cfg_o | output | 1792 | All chip-select configuration words, flattened |

## Verification
The assertions assume that the master presents at most one access per cycle, and that reset is asserted at the start of simulation. They also assume that `irq_evt` is only meaningful inside the enable mask. The stimulus issues one access per clock and drives inputs on the falling edge. Random traffic masks the self-reset bit out of every write to 0x010, so that only the directed case resets the block. Event pulses come from directed sequences, one of which collides an event with a clear on the same bit.

// File: rtl/memcfg_pkg.sv
package memcfg_pkg;
    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int NUM_CS   = 8;
    localparam int CS_WORDS = 7;
    localparam int CS_BASE  = 'h060;
    localparam int CS_STRIDE = 'h30;
    localparam int ECC_SLOTS = 9;
    localparam int EVT_W    = 16;
    localparam int FIFO_W   = 7;
    localparam int BANK_W   = CS_WORDS * DATA_W;

    localparam logic [DATA_W-1:0] M_SYS   = 32'h0000_0019;
    localparam logic [DATA_W-1:0] M_IEN   = 32'h0000_0F03;
    localparam logic [DATA_W-1:0] M_TO    = 32'h0000_1FF1;
    localparam logic [DATA_W-1:0] M_GCFG  = 32'h0000_0F13;
    localparam logic [DATA_W-1:0] R_GCFG  = 32'h0000_0A00;
    localparam logic [DATA_W-1:0] M_PF1   = 32'h7F8F_7FBF;
    localparam logic [DATA_W-1:0] R_PF1   = 32'h0000_4000;
    localparam logic [DATA_W-1:0] M_PF2   = 32'h0000_3FFF;
    localparam logic [DATA_W-1:0] M_ESZ   = 32'h3FCF_F1FF;
    localparam logic [DATA_W-1:0] R_ESZ   = 32'h3FCF_F000;
    localparam logic [DATA_W-1:0] ECFG_SET = 32'h0000_008F;
    localparam logic [FIFO_W-1:0] FIFO_FULL = 7'h40;

    localparam logic [ADDR_W-1:0] A_REV   = 12'h000;
    localparam logic [ADDR_W-1:0] A_SYS   = 12'h010;
    localparam logic [ADDR_W-1:0] A_SDONE = 12'h014;
    localparam logic [ADDR_W-1:0] A_IST   = 12'h018;
    localparam logic [ADDR_W-1:0] A_IEN   = 12'h01C;
    localparam logic [ADDR_W-1:0] A_TO    = 12'h040;
    localparam logic [ADDR_W-1:0] A_GCFG  = 12'h050;
    localparam logic [ADDR_W-1:0] A_GSTAT = 12'h054;
    localparam logic [ADDR_W-1:0] A_PF1   = 12'h1E0;
    localparam logic [ADDR_W-1:0] A_PF2   = 12'h1E4;
    localparam logic [ADDR_W-1:0] A_PCTL  = 12'h1EC;
    localparam logic [ADDR_W-1:0] A_PSTAT = 12'h1F0;
    localparam logic [ADDR_W-1:0] A_ECFG  = 12'h1F4;
    localparam logic [ADDR_W-1:0] A_ECTL  = 12'h1F8;
    localparam logic [ADDR_W-1:0] A_ESZ   = 12'h1FC;

    function automatic logic [DATA_W-1:0] cs_word_mask(input int k);
        case (k)
            0:       return 32'hFFEF_3E13;
            1, 2:    return 32'h001F_1F8F;
            3:       return 32'h1F8F_1F8F;
            4:       return 32'h0F1F_1F1F;
            5:       return 32'h0000_0FCF;
            default: return 32'h0000_0F7F;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] cs_word_reset(input int n, input int k);
        case (k)
            0:       return (n == 0) ? 32'h0 : 32'h0000_1000;
            1:       return 32'h0010_1001;
            2:       return 32'h0002_0201;
            3:       return 32'h1003_1003;
            4:       return 32'h010F_1111;
            5:       return 32'h0;
            default: return (n == 0) ? 32'h0000_0F40 : 32'h0000_0F00;
        endcase
    endfunction
endpackage

// File: rtl/memcfg_cs_bank.sv
module memcfg_cs_bank
    import memcfg_pkg::*;
#(
    parameter int CS_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word,
    output logic [BANK_W-1:0] cfg_o
);
    localparam int BANK_BASE = CS_BASE + CS_IDX * CS_STRIDE;

    logic [DATA_W-1:0] word_q   [CS_WORDS];
    logic [CS_WORDS-1:0] hit;

    for (genvar k = 0; k < CS_WORDS; k++) begin : g_word
        localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(BANK_BASE + k * 4);
        localparam logic [DATA_W-1:0] WMASK = cs_word_mask(k);
        localparam logic [DATA_W-1:0] WRST  = cs_word_reset(CS_IDX, k);

        assign hit[k] = (addr == WADDR);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[k] <= WRST;
            end else if (soft_rst) begin
                word_q[k] <= WRST;
            end else if (wr_en && hit[k]) begin
                word_q[k] <= wdata & WMASK;
            end
        end

        assign cfg_o[k*DATA_W +: DATA_W] = word_q[k];

        AST_CS_WMASK: assert property (@(posedge clk) disable iff (!rst_n)
            (word_q[k] & ~WMASK) == '0);  // R6
    end

    always_comb begin
        rd_word = '0;
        for (int k = 0; k < CS_WORDS; k++) begin
            if (hit[k]) rd_word = word_q[k];
        end
    end
endmodule

// File: rtl/memcfg_irq.sv
module memcfg_irq
    import memcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_ist,
    input  logic              wr_ien,
    input  logic [DATA_W-1:0] wdata,
    input  logic [EVT_W-1:0]  irq_evt,
    output logic [DATA_W-1:0] ist_q,
    output logic [DATA_W-1:0] ien_q,
    output logic              irq_o
);
    logic [DATA_W-1:0] evt_ext;
    logic [DATA_W-1:0] clr_bits;

    assign evt_ext  = {{(DATA_W-EVT_W){1'b0}}, irq_evt} & M_IEN;
    assign clr_bits = wr_ist ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ist_q <= '0;
            ien_q <= '0;
        end else if (soft_rst) begin
            ist_q <= '0;
            ien_q <= '0;
        end else begin
            ist_q <= (ist_q & ~clr_bits) | evt_ext;
            if (wr_ien) ien_q <= wdata & M_IEN;
        end
    end

    assign irq_o = |(ist_q & ien_q);

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ien && !soft_rst && ((wdata & M_IEN) == '0)) |=> !irq_o);  // R4
    AST_IRQ_SOFTRST: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!irq_o && ist_q == '0));  // R2
    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && evt_ext[0]) |=> ist_q[0]);  // R3
endmodule

// File: rtl/memcfg_pref_ecc.sv
module memcfg_pref_ecc
    import memcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_pf1,
    input  logic              wr_pf2,
    input  logic              wr_pctl,
    input  logic              wr_ecfg,
    input  logic              wr_ectl,
    input  logic              wr_esz,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] pf1_q,
    output logic [DATA_W-1:0] pf2_q,
    output logic              pctl_q,
    output logic [DATA_W-1:0] pstat,
    output logic [DATA_W-1:0] ecfg_q,
    output logic [3:0]        eptr_q,
    output logic [DATA_W-1:0] esz_q,
    output logic              ecc_clr_o
);
    logic [FIFO_W-1:0] fifo_q;
    logic              ptr_bad;
    logic              over_thr;

    assign ptr_bad  = (wdata[3:0] == 4'd0) || (int'(wdata[3:0]) > ECC_SLOTS);
    assign over_thr = fifo_q > pf1_q[14:8];
    assign pstat    = {1'b0, fifo_q, 7'b0, over_thr, 16'h0};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pf1_q <= R_PF1;
            pf2_q <= '0;
            pctl_q <= 1'b0;
            fifo_q <= '0;
        end else if (soft_rst) begin
            pf1_q <= R_PF1;
            pf2_q <= '0;
            pctl_q <= 1'b0;
            fifo_q <= '0;
        end else begin
            if (wr_pf1) pf1_q <= wdata & M_PF1;
            if (wr_pf2) pf2_q <= wdata & M_PF2;
            if (wr_pctl) begin
                pctl_q <= wdata[0];
                if (wdata[0]) fifo_q <= pf1_q[0] ? FIFO_FULL : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ecfg_q <= '0;
            eptr_q <= '0;
            esz_q <= R_ESZ;
            ecc_clr_o <= 1'b0;
        end else begin
            ecc_clr_o <= soft_rst || (wr_ectl && wdata[8]);
            if (soft_rst) begin
                ecfg_q <= '0;
                eptr_q <= '0;
                esz_q <= R_ESZ;
            end else begin
                if (wr_esz) esz_q <= wdata & M_ESZ;
                if (wr_ecfg) begin
                    ecfg_q <= ECFG_SET;
                end else if (wr_ectl && ptr_bad) begin
                    ecfg_q <= ecfg_q & ~32'h1;
                end
                if (wr_ectl) eptr_q <= ptr_bad ? 4'd0 : wdata[3:0];
            end
        end
    end

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(eptr_q) <= ECC_SLOTS);  // R10
    AST_FIFO_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_q == '0) || (fifo_q == FIFO_FULL));  // R8
    AST_ECC_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ectl && wdata[8]) |=> ecc_clr_o);  // R10
endmodule

// File: rtl/memcfg_regfile.sv
module memcfg_regfile
    import memcfg_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         rdata,
    input  logic [EVT_W-1:0]          irq_evt,
    output logic                      irq_o,
    output logic                      ecc_clr_o,
    output logic [NUM_CS*BANK_W-1:0]  cs_cfg_o
);
    logic soft_rst;
    logic [DATA_W-1:0] sys_q, to_q, gcfg_q;
    logic [DATA_W-1:0] ist_q, ien_q;
    logic [DATA_W-1:0] pf1_q, pf2_q, pstat, ecfg_q, esz_q;
    logic              pctl_q;
    logic [3:0]        eptr_q;
    logic [DATA_W-1:0] bank_rd [NUM_CS];
    logic [DATA_W-1:0] cs_rd;

    assign soft_rst = wr_en && (addr == A_SYS) && wdata[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sys_q  <= '0;
            to_q   <= '0;
            gcfg_q <= R_GCFG;
        end else begin
            if (wr_en && addr == A_SYS) sys_q <= wdata & M_SYS;
            if (soft_rst) begin
                to_q   <= '0;
                gcfg_q <= R_GCFG;
            end else begin
                if (wr_en && addr == A_TO)   to_q   <= wdata & M_TO;
                if (wr_en && addr == A_GCFG) gcfg_q <= wdata & M_GCFG;
            end
        end
    end

    memcfg_irq u_irq (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .wr_ist(wr_en && addr == A_IST), .wr_ien(wr_en && addr == A_IEN),
        .wdata(wdata), .irq_evt(irq_evt),
        .ist_q(ist_q), .ien_q(ien_q), .irq_o(irq_o)
    );

    memcfg_pref_ecc u_pref_ecc (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .wr_pf1(wr_en && addr == A_PF1), .wr_pf2(wr_en && addr == A_PF2),
        .wr_pctl(wr_en && addr == A_PCTL), .wr_ecfg(wr_en && addr == A_ECFG),
        .wr_ectl(wr_en && addr == A_ECTL), .wr_esz(wr_en && addr == A_ESZ),
        .wdata(wdata),
        .pf1_q(pf1_q), .pf2_q(pf2_q), .pctl_q(pctl_q), .pstat(pstat),
        .ecfg_q(ecfg_q), .eptr_q(eptr_q), .esz_q(esz_q), .ecc_clr_o(ecc_clr_o)
    );

    for (genvar n = 0; n < NUM_CS; n++) begin : g_cs
        memcfg_cs_bank #(.CS_IDX(n)) u_bank (
            .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
            .wr_en(wr_en), .addr(addr), .wdata(wdata),
            .rd_word(bank_rd[n]),
            .cfg_o(cs_cfg_o[n*BANK_W +: BANK_W])
        );
    end

    always_comb begin
        cs_rd = '0;
        for (int n = 0; n < NUM_CS; n++) cs_rd = cs_rd | bank_rd[n];
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (addr)
                A_REV:   rdata = 32'h20;
                A_SYS:   rdata = sys_q;
                A_SDONE: rdata = 32'h1;
                A_IST:   rdata = ist_q;
                A_IEN:   rdata = ien_q;
                A_TO:    rdata = to_q;
                A_GCFG:  rdata = gcfg_q;
                A_GSTAT: rdata = 32'h1;
                A_PF1:   rdata = pf1_q;
                A_PF2:   rdata = pf2_q;
                A_PCTL:  rdata = {31'b0, pctl_q};
                A_PSTAT: rdata = pstat;
                A_ECFG:  rdata = ecfg_q;
                A_ECTL:  rdata = {28'b0, eptr_q};
                A_ESZ:   rdata = esz_q;
                default: rdata = cs_rd;
            endcase
        end
    end

    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (to_q == '0 && gcfg_q == R_GCFG && pf1_q == R_PF1));  // R2
    AST_SYS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_q & ~M_SYS) == '0);  // R2
endmodule

// File: tb/memcfg_regfile_tb.sv
module memcfg_regfile_tb;
    import memcfg_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [15:0] irq_evt = '0;
    logic irq_o, ecc_clr_o;
    logic [1791:0] cs_cfg_o;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    memcfg_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_evt(irq_evt), .irq_o(irq_o),
        .ecc_clr_o(ecc_clr_o), .cs_cfg_o(cs_cfg_o)
    );

    // reference state
    logic [31:0] m_sys, m_ist, m_ien, m_to, m_gcfg, m_pf1, m_pf2, m_ecfg, m_esz;
    logic        m_pctl;
    logic [6:0]  m_fifo;
    logic [3:0]  m_ptr;
    logic [31:0] m_cs [8][7];

    function automatic logic [31:0] b_mask(input int k);
        case (k)
            0: return 32'hFFEF3E13;
            1: return 32'h001F1F8F;
            2: return 32'h001F1F8F;
            3: return 32'h1F8F1F8F;
            4: return 32'h0F1F1F1F;
            5: return 32'h00000FCF;
            default: return 32'h00000F7F;
        endcase
    endfunction

    function automatic logic [31:0] b_rst(input int n, input int k);
        case (k)
            0: return n == 0 ? 32'h0 : 32'h1000;
            1: return 32'h101001;
            2: return 32'h020201;
            3: return 32'h10031003;
            4: return 32'h010F1111;
            5: return 32'h0;
            default: return n == 0 ? 32'hF40 : 32'hF00;
        endcase
    endfunction

    task automatic model_reset();
        m_sys = 0; m_ist = 0; m_ien = 0; m_to = 0; m_gcfg = 32'hA00;
        m_pf1 = 32'h4000; m_pf2 = 0; m_pctl = 0; m_fifo = 0;
        m_ecfg = 0; m_ptr = 0; m_esz = 32'h3FCFF000;
        for (int n = 0; n < 8; n++)
            for (int k = 0; k < 7; k++) m_cs[n][k] = b_rst(n, k);
    endtask

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        int off;
        if (a >= 12'h060 && a < 12'h1E0) begin
            off = int'(a) - 'h60;
            if ((off % 48) < 28 && (off % 4) == 0) m_cs[off/48][(off%48)/4] = d & b_mask((off%48)/4);
            return;
        end
        case (a)
            12'h010: begin if (d[1]) model_reset(); m_sys = d & 32'h19; end
            12'h018: m_ist = m_ist & ~d;
            12'h01C: m_ien = d & 32'hF03;
            12'h040: m_to = d & 32'h1FF1;
            12'h050: m_gcfg = d & 32'hF13;
            12'h1E0: m_pf1 = d & 32'h7F8F7FBF;
            12'h1E4: m_pf2 = d & 32'h3FFF;
            12'h1EC: begin m_pctl = d[0]; if (d[0]) m_fifo = m_pf1[0] ? 7'h40 : 7'h0; end
            12'h1F4: m_ecfg = 32'h8F;
            12'h1F8: begin
                m_ptr = d[3:0];
                if (d[3:0] == 0 || d[3:0] > 9) begin m_ptr = 0; m_ecfg[0] = 1'b0; end
            end
            12'h1FC: m_esz = d & 32'h3FCFF1FF;
            default: ;
        endcase
    endtask

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        int off;
        if (a >= 12'h060 && a < 12'h1E0) begin
            off = int'(a) - 'h60;
            if ((off % 48) < 28 && (off % 4) == 0) return m_cs[off/48][(off%48)/4];
            return 0;
        end
        case (a)
            12'h000: return 32'h20;
            12'h010: return m_sys;
            12'h014: return 32'h1;
            12'h018: return m_ist;
            12'h01C: return m_ien;
            12'h040: return m_to;
            12'h050: return m_gcfg;
            12'h054: return 32'h1;
            12'h1E0: return m_pf1;
            12'h1E4: return m_pf2;
            12'h1EC: return {31'b0, m_pctl};
            12'h1F0: return {1'b0, m_fifo, 7'b0, (m_fifo > m_pf1[14:8]), 16'h0};
            12'h1F4: return m_ecfg;
            12'h1F8: return {28'b0, m_ptr};
            12'h1FC: return m_esz;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0;
        model_write(a, d);
    endtask

    task automatic rd_chk(input logic [11:0] a, input string req);
        @(negedge clk);
        rd_en = 1; addr = a;
        #2;
        chk(req, rdata, exp_read(a));
        rd_en = 0;
    endtask

    task automatic bus_chk(input string req);
        logic [1791:0] e;
        for (int n = 0; n < 8; n++)
            for (int k = 0; k < 7; k++) e[(n*7+k)*32 +: 32] = m_cs[n][k];
        n_chk++;
        if (cs_cfg_o !== e) begin
            n_bad++;
            $display("FAIL %s: cs_cfg_o mismatch actual word0 0x%08h expected 0x%08h",
                     req, cs_cfg_o[31:0], e[31:0]);
        end
    endtask

    task automatic irq_chk(input string req);
        chk(req, {31'b0, irq_o}, {31'b0, |(m_ist & m_ien)});
    endtask

    task automatic pulse_evt(input logic [15:0] v);
        @(negedge clk);
        irq_evt = v;
        @(negedge clk);
        irq_evt = 0;
        m_ist = m_ist | ({16'b0, v} & 32'hF03);
    endtask

    localparam logic [11:0] GLIST [15] = '{12'h000, 12'h010, 12'h014, 12'h018, 12'h01C,
        12'h040, 12'h050, 12'h054, 12'h1E0, 12'h1E4, 12'h1EC, 12'h1F0, 12'h1F4, 12'h1F8, 12'h1FC};

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // reset state (R1 R2 R5 R7 R8 R11)
        for (int i = 0; i < 15; i++) rd_chk(GLIST[i], "R1/R5/R8/R11 reset");
        bus_chk("R7 reset");
        rd_chk(12'h060, "R7 cs0 word0");
        rd_chk(12'h078, "R7 cs0 word6");
        rd_chk(12'h0A8, "R7 cs1 word6");
        irq_chk("R4 reset");

        // read-only and unmapped (R1 R12)
        do_write(12'h000, 32'hFFFF_FFFF); rd_chk(12'h000, "R1 rev write");
        do_write(12'h014, 32'h0);         rd_chk(12'h014, "R1 done write");
        do_write(12'h1F0, 32'hFFFF_FFFF); rd_chk(12'h1F0, "R1 pstat write");
        do_write(12'h07C, 32'hFFFF_FFFF); rd_chk(12'h07C, "R12 cs pad");
        do_write(12'h061, 32'hFFFF_FFFF); rd_chk(12'h060, "R12 unaligned");
        bus_chk("R12 bus after ignored writes");
        do_write(12'h300, 32'h1234_5678); rd_chk(12'h300, "R12 unmapped");

        // interrupts (R3 R4)
        do_write(12'h01C, 32'hFFFF_FFFF); rd_chk(12'h01C, "R3 enable mask");
        do_write(12'h01C, 32'h0000_0003);
        pulse_evt(16'hF1F1); rd_chk(12'h018, "R3 status set");
        irq_chk("R4 asserted");
        do_write(12'h018, 32'h0000_0001); rd_chk(12'h018, "R3 w1c");
        irq_chk("R4 after clear");
        do_write(12'h01C, 32'h0000_0F03); irq_chk("R4 enable wider");
        @(negedge clk);
        wr_en = 1; addr = 12'h018; wdata = 32'h100; irq_evt = 16'h0100;
        @(negedge clk);
        wr_en = 0; irq_evt = 0;
        m_ist = (m_ist & ~32'h100) | 32'h100;
        rd_chk(12'h018, "R3 set beats clear");

        // prefetch (R8 R9)
        do_write(12'h1E0, 32'hFFFF_FFFF); rd_chk(12'h1E0, "R8 pf1 mask");
        do_write(12'h1E0, 32'h0000_3F01);
        do_write(12'h1EC, 32'h1); rd_chk(12'h1F0, "R9 over threshold");
        do_write(12'h1E0, 32'h0000_4001); rd_chk(12'h1F0, "R9 equal threshold");
        do_write(12'h1E0, 32'h0000_0000);
        do_write(12'h1EC, 32'h0); rd_chk(12'h1F0, "R8 write 0 keeps count");
        do_write(12'h1EC, 32'h1); rd_chk(12'h1F0, "R8 load zero");
        rd_chk(12'h1EC, "R8 start bit");

        // ECC control (R10)
        do_write(12'h1F4, 32'h0); rd_chk(12'h1F4, "R10 cfg set");
        do_write(12'h1F8, 32'h105);
        chk("R10 clear strobe", {31'b0, ecc_clr_o}, 32'h1);
        @(negedge clk);
        chk("R10 strobe one cycle", {31'b0, ecc_clr_o}, 32'h0);
        rd_chk(12'h1F8, "R10 ptr 5");
        do_write(12'h1F8, 32'h9);  rd_chk(12'h1F8, "R10 ptr 9");
        rd_chk(12'h1F4, "R10 cfg kept");
        do_write(12'h1F8, 32'hA);  rd_chk(12'h1F8, "R10 ptr 10");
        rd_chk(12'h1F4, "R10 cfg bit0 cleared");
        do_write(12'h1F4, 32'h0);
        do_write(12'h1F8, 32'h0);  rd_chk(12'h1F4, "R10 ptr 0 clears");

        // random traffic
        for (int it = 0; it < 400; it++) begin
            logic [11:0] a;
            logic [31:0] d;
            int r;
            r = int'($urandom % 10);
            d = $urandom;
            if (r < 6) a = 12'(12'h060 + ($urandom % 8) * 12'h30 + ($urandom % 9) * 4);
            else if (r < 9) a = GLIST[$urandom % 15];
            else a = 12'($urandom) & 12'hFFC;
            if (a == 12'h010) d[1] = 1'b0;
            do_write(a, d);
            rd_chk(a, "R5/R6/R8/R11 random");
            if (it % 20 == 0) bus_chk("R6 random bus");
        end
        irq_chk("R4 after random");

        // self reset (R2)
        do_write(12'h040, 32'hFFFF);
        do_write(12'h01C, 32'hF03);
        pulse_evt(16'h0001);
        irq_chk("R4 before reset");
        do_write(12'h010, 32'h0000_001B);
        chk("R2 strobe", {31'b0, ecc_clr_o}, 32'h1);
        irq_chk("R2 irq low");
        rd_chk(12'h010, "R2 sys value");
        rd_chk(12'h040, "R2 timeout reset");
        rd_chk(12'h050, "R2 gcfg reset");
        rd_chk(12'h01C, "R2 enable reset");
        rd_chk(12'h1FC, "R2 size reset");
        bus_chk("R2 cs reset");

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule